// File: doc/BRIEF.md
# Digital PLL Loop Controller

This block closes a digital phase-locked loop around a disciplined oscillator. On every sample strobe it takes one signed sample from each of two quadrature phase-detector channels and forms a phase error. It runs that error through a proportional-plus-integral filter whose integrator is held entirely in registers, and it produces an unsigned tuning word for the oscillator's DAC. The loop starts at its widest bandwidth. Once it judges itself locked, it moves to a selectable narrow working bandwidth. It rebalances the integrator in the same step, so the tuning word does not jump.

Lock is judged from two things: the size of the phase error and the sample-to-sample change of that error, which stands in for frequency error. If strobes stop arriving, the block declares the reference lost and enters holdover. In holdover the tuning word is frozen and the lock flag is cleared. The next strobe resumes the loop from the frozen integrator.

Top module: `dpll_ctrl`

## Requirements
- R1: After reset the tuning word is midscale (8388608), and both the lock flag and the holdover flag are low.
- R2: The phase error e is taken from the Q sample when the I sample is zero or positive. When I is negative, e is forced to +511 if Q is zero or positive, and to -511 if Q is negative. Both samples are 10-bit two's complement.
- R3: On each strobe, with bandwidth index b (0 while unlocked), the integrator gains floor((e*64)/2^(2b)) and the tuning word becomes integrator + floor((e*256)/2^b). Both results appear in the cycle after the strobe.
- R4: A sum above 16777215 or below 0 is clamped to that limit. On such a strobe the integrator keeps its previous value, so the next small error pulls the word straight off the limit.
- R5: A strobe is good when |e| <= phase threshold and |e - previous e| <= frequency threshold. While unlocked, 8 consecutive good strobes set the lock flag.
- R6: While locked, 4 consecutive strobes that are not good clear the lock flag.
- R7: When the target index (the working index if locked and not in holdover, otherwise 0) differs from the current one, the change happens on the next cycle without a strobe. The integrator gains P(e_last, old) - P(e_last, new), where P is the proportional term of R3, and the tuning word does not change.
- R8: After 64 clock cycles without a strobe, holdover is set and the lock flag is cleared in the same cycle. The tuning word holds its value for as long as holdover lasts.
- R9: The first strobe during holdover clears holdover and applies the R3 update from the frozen integrator.
- R10: The tuning word changes only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_vld | input | 1 | One-cycle strobe marking a new sample pair |
| sample_i | input | 10 | In-phase detector sample, signed |
| sample_q | input | 10 | Quadrature detector sample, signed |
| work_bw | input | 3 | Working bandwidth index; larger is narrower |
| phase_thr | input | 10 | Phase-error magnitude limit for a good strobe |
| freq_thr | input | 11 | Limit on the sample-to-sample change of the error |
| tune_word | output | 24 | Unsigned oscillator tuning word |
| locked | output | 1 | Lock flag |
| holdover | output | 1 | Reference-lost flag; tuning frozen while high |

## Verification
The hardest states to reach from the ports are the clamped tuning word with a wound-down integrator, and holdover entered while locked at the narrow bandwidth. The stimulus feeds a long run of full-scale errors until the word pins at each rail, then applies a zero error to show the word leaves the rail at once. It then locks the loop at a narrow index, withholds strobes past the timeout, and confirms that the word holds while the bandwidth falls back silently. Finally it confirms that the next strobe resumes from the frozen integrator.

// File: rtl/dpll_pkg.sv
// Shared types for the digital PLL loop controller.
package dpll_pkg;
    // Bandwidth index: 0 is widest, each step halves the proportional gain
    typedef logic [2:0] bw_idx_t;
    localparam bw_idx_t BW_ACQ = 3'd0;
endpackage

// File: rtl/dpll_err_sel.sv
// Phase error former. Passes the Q sample through when the I sample shows
// the error is inside +/- a quarter cycle. Otherwise it pins the error at
// full scale with the sign of Q, which extends the detector range.
// Assumes both samples are two's complement.
module dpll_err_sel #(
    parameter int SAMPLE_W = 10
) (
    input  logic [SAMPLE_W-1:0]        sample_i,
    input  logic [SAMPLE_W-1:0]        sample_q,
    output logic signed [SAMPLE_W-1:0] err
);
    localparam logic signed [SAMPLE_W-1:0] FULL_POS = SAMPLE_W'((1 << (SAMPLE_W-1)) - 1);
    localparam logic signed [SAMPLE_W-1:0] FULL_NEG = -FULL_POS;

    // select direct or extended-range error
    always_comb begin
        if ($signed(sample_i) < 0)
            err = ($signed(sample_q) < 0) ? FULL_NEG : FULL_POS;
        else
            err = $signed(sample_q);
    end
endmodule

// File: rtl/dpll_loop_filt.sv
// Proportional-plus-integral loop filter with a register integrator.
// The integrator moves only on a strobe or on a bandwidth rebalance.
// The output clamps to the unsigned OUT_W range, and the integrator is
// held when the sum would leave that range.
// Assumes strobe and rebal_en are never high together.
module dpll_loop_filt
    import dpll_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int OUT_W    = 24,
    parameter int P_SHIFT  = 8,
    parameter int I_SHIFT  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strobe,
    input  logic signed [SAMPLE_W-1:0] err,
    input  bw_idx_t                    bw_cur,
    input  logic                       rebal_en,
    input  bw_idx_t                    bw_next,
    output logic [OUT_W-1:0]           tune_word,
    output logic signed [SAMPLE_W-1:0] err_last
);
    localparam int INT_W = OUT_W + 4;
    localparam logic signed [INT_W-1:0] TOP_V = INT_W'((64'd1 << OUT_W) - 64'd1);
    localparam logic signed [INT_W-1:0] MID_V = INT_W'(64'd1 << (OUT_W - 1));

    logic signed [INT_W-1:0] integ;
    logic signed [INT_W-1:0] incr_c;
    logic signed [INT_W-1:0] sum_c;
    logic signed [INT_W-1:0] rebal_c;

    // proportional term: error scaled up by P_SHIFT, down by the index
    function automatic logic signed [INT_W-1:0] prop_of(
        input logic signed [SAMPLE_W-1:0] e,
        input bw_idx_t                    b
    );
        logic signed [INT_W-1:0] x;
        x = INT_W'(e);
        x = x <<< P_SHIFT;
        return x >>> b;
    endfunction

    // integral step: scaled up by I_SHIFT, down by twice the index
    function automatic logic signed [INT_W-1:0] incr_of(
        input logic signed [SAMPLE_W-1:0] e,
        input bw_idx_t                    b
    );
        logic signed [INT_W-1:0] x;
        logic [3:0]              sh;
        x  = INT_W'(e);
        x  = x <<< I_SHIFT;
        sh = {b, 1'b0};
        return x >>> sh;
    endfunction

    // next-state arithmetic for strobe and rebalance
    always_comb begin
        incr_c  = incr_of(err, bw_cur);
        sum_c   = integ + incr_c + prop_of(err, bw_cur);
        rebal_c = integ + prop_of(err_last, bw_cur) - prop_of(err_last, bw_next);
    end

    // integrator, clamped output and last-error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ     <= MID_V;
            tune_word <= MID_V[OUT_W-1:0];
            err_last  <= '0;
        end else if (strobe) begin
            err_last <= err;
            if (sum_c > TOP_V) begin
                tune_word <= TOP_V[OUT_W-1:0];
            end else if (sum_c < 0) begin
                tune_word <= '0;
            end else begin
                tune_word <= sum_c[OUT_W-1:0];
                integ     <= integ + incr_c;
            end
        end else if (rebal_en) begin
            integ <= rebal_c;
        end
    end
endmodule

// File: rtl/dpll_lock_det.sv
// Lock qualifier with hysteresis. A strobe is good when both the phase error
// and its change since the last strobe are within limits. LOCK_N good strobes
// in a row set the flag; UNLOCK_M bad strobes in a row clear it.
// clear forces unlock and is assumed never to coincide with a strobe.
module dpll_lock_det #(
    parameter int SAMPLE_W = 10,
    parameter int LOCK_N   = 8,
    parameter int UNLOCK_M = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strobe,
    input  logic                       clear,
    input  logic signed [SAMPLE_W-1:0] err,
    input  logic signed [SAMPLE_W-1:0] err_last,
    input  logic [SAMPLE_W-1:0]        phase_thr,
    input  logic [SAMPLE_W:0]          freq_thr,
    output logic                       locked
);
    localparam int MAX_RUN = (LOCK_N > UNLOCK_M) ? LOCK_N : UNLOCK_M;
    localparam int CNT_W   = $clog2(MAX_RUN + 1);

    logic [CNT_W-1:0]        run_cnt;
    logic signed [SAMPLE_W:0] e_x, d_x;
    logic [SAMPLE_W:0]        e_mag, d_mag;
    logic                     good, advance, run_done;

    // magnitudes, good test and streak bookkeeping
    always_comb begin
        e_x      = (SAMPLE_W+1)'(err);
        d_x      = e_x - (SAMPLE_W+1)'(err_last);
        e_mag    = (e_x < 0) ? -e_x : e_x;
        d_mag    = (d_x < 0) ? -d_x : d_x;
        good     = (e_mag <= {1'b0, phase_thr}) && (d_mag <= freq_thr);
        advance  = locked ? !good : good;
        run_done = run_cnt == (locked ? CNT_W'(UNLOCK_M - 1) : CNT_W'(LOCK_N - 1));
    end

    // streak counter and lock flag
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            locked  <= 1'b0;
            run_cnt <= '0;
        end else if (strobe) begin
            if (advance && run_done) begin
                locked  <= !locked;
                run_cnt <= '0;
            end else if (advance) begin
                run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/dpll_ref_watch.sv
// Reference-loss watchdog. Counts cycles since the last strobe and raises
// holdover after TIMEOUT of them. hold_enter pulses in the cycle before
// holdover goes high. A strobe clears holdover.
module dpll_ref_watch #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic holdover,
    output logic hold_enter
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);

    logic [CNT_W-1:0] gap_cnt;

    // detect the last idle cycle before timeout
    always_comb begin
        hold_enter = !strobe && !holdover && (gap_cnt == CNT_W'(TIMEOUT - 1));
    end

    // gap counter and holdover flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt  <= '0;
            holdover <= 1'b0;
        end else if (strobe) begin
            gap_cnt  <= '0;
            holdover <= 1'b0;
        end else if (hold_enter) begin
            holdover <= 1'b1;
        end else if (!holdover) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dpll_ctrl.sv
// Digital PLL loop controller top. Forms the phase error, filters it into a
// tuning word, qualifies lock and watches for reference loss. It also steps
// the bandwidth index between acquisition and the working setting, moving it
// only on a cycle with no strobe so the filter can rebalance.
module dpll_ctrl
    import dpll_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int OUT_W    = 24,
    parameter int P_SHIFT  = 8,
    parameter int I_SHIFT  = 6,
    parameter int LOCK_N   = 8,
    parameter int UNLOCK_M = 4,
    parameter int TIMEOUT  = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_vld,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [SAMPLE_W-1:0] sample_q,
    input  logic [2:0]          work_bw,
    input  logic [SAMPLE_W-1:0] phase_thr,
    input  logic [SAMPLE_W:0]   freq_thr,
    output logic [OUT_W-1:0]    tune_word,
    output logic                locked,
    output logic                holdover
);
    logic signed [SAMPLE_W-1:0] err;
    logic signed [SAMPLE_W-1:0] err_last;
    logic                       hold_enter;
    bw_idx_t                    bw_cur;
    bw_idx_t                    bw_tgt;
    logic                       rebal_en;

    dpll_err_sel #(.SAMPLE_W(SAMPLE_W)) err_sel_i (
        .sample_i (sample_i),
        .sample_q (sample_q),
        .err      (err)
    );

    dpll_loop_filt #(
        .SAMPLE_W (SAMPLE_W),
        .OUT_W    (OUT_W),
        .P_SHIFT  (P_SHIFT),
        .I_SHIFT  (I_SHIFT)
    ) filt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (sample_vld),
        .err       (err),
        .bw_cur    (bw_cur),
        .rebal_en  (rebal_en),
        .bw_next   (bw_tgt),
        .tune_word (tune_word),
        .err_last  (err_last)
    );

    dpll_lock_det #(
        .SAMPLE_W (SAMPLE_W),
        .LOCK_N   (LOCK_N),
        .UNLOCK_M (UNLOCK_M)
    ) lock_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (sample_vld),
        .clear     (hold_enter),
        .err       (err),
        .err_last  (err_last),
        .phase_thr (phase_thr),
        .freq_thr  (freq_thr),
        .locked    (locked)
    );

    dpll_ref_watch #(.TIMEOUT(TIMEOUT)) watch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (sample_vld),
        .holdover   (holdover),
        .hold_enter (hold_enter)
    );

    // pick the target index and decide when to switch
    always_comb begin
        bw_tgt   = (locked && !holdover) ? bw_idx_t'(work_bw) : BW_ACQ;
        rebal_en = !sample_vld && (bw_tgt != bw_cur);
    end

    // current bandwidth index
    always_ff @(posedge clk) begin
        if (!rst_n)
            bw_cur <= BW_ACQ;
        else if (rebal_en)
            bw_cur <= bw_tgt;
    end
endmodule

// File: rtl/dpll_ctrl_chk.sv
// Temporal checks on the loop controller, bound to every instance.
module dpll_ctrl_chk #(
    parameter int OUT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_vld,
    input logic [OUT_W-1:0] tune_word,
    input logic             locked,
    input logic             holdover,
    input logic [2:0]       bw_cur
);
    // R10
    tune_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> $stable(tune_word));

    // R5
    lock_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(sample_vld));

    // R6
    unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> ($past(sample_vld) || holdover));

    // R8
    hold_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        holdover |-> !locked);

    // R9
    hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (holdover && sample_vld) |=> !holdover);

    // R7
    bw_off_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bw_cur) |-> !$past(sample_vld));
endmodule

bind dpll_ctrl dpll_ctrl_chk #(.OUT_W(OUT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_vld (sample_vld),
    .tune_word  (tune_word),
    .locked     (locked),
    .holdover   (holdover),
    .bw_cur     (bw_cur)
);

// File: tb/dpll_ctrl_tb_top.sv
// Scoreboard bench: the driver task predicts each strobe's result and queues
// it; the monitor pops and compares on the falling edge after the strobe.
module dpll_ctrl_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int  LOCK_N   = 8;
    localparam int  UNLOCK_M = 4;
    localparam int  TIMEOUT  = 64;
    localparam longint TMAX  = 16777215;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_vld = 1'b0;
    logic [9:0]  sample_i = '0;
    logic [9:0]  sample_q = '0;
    logic [2:0]  work_bw = 3'd0;
    logic [9:0]  phase_thr = 10'd8;
    logic [10:0] freq_thr = 11'd4;
    logic [23:0] tune_word;
    logic        locked;
    logic        holdover;

    always #2.5 clk = ~clk;

    dpll_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (sample_vld),
        .sample_i   (sample_i),
        .sample_q   (sample_q),
        .work_bw    (work_bw),
        .phase_thr  (phase_thr),
        .freq_thr   (freq_thr),
        .tune_word  (tune_word),
        .locked     (locked),
        .holdover   (holdover)
    );

    typedef struct {
        longint tune;
        bit     lock;
        string  tag;
    } exp_t;

    exp_t   sb_q[$];
    int     n_chk = 0;
    int     n_bad = 0;

    // reference model state
    longint m_integ = 8388608;
    longint m_tune  = 8388608;
    int     m_bw    = 0;
    int     m_elast = 0;
    bit     m_lock  = 0;
    int     m_cnt   = 0;
    bit     m_hold  = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    function automatic longint m_prop(input int e, input int b);
        return (longint'(e) * 256) >>> b;
    endfunction

    function automatic longint m_incr(input int e, input int b);
        return (longint'(e) * 64) >>> (2 * b);
    endfunction

    // R7: bandwidth move with integrator rebalance
    task automatic m_rebal();
        int tgt;
        tgt = (m_lock && !m_hold) ? int'(work_bw) : 0;
        if (tgt != m_bw) begin
            m_integ = m_integ + m_prop(m_elast, m_bw) - m_prop(m_elast, tgt);
            m_bw    = tgt;
        end
    endtask

    // driver: predict, queue, then apply one strobe and a short gap
    task automatic strobe(input int i_v, input int q_v, input string tag);
        int     e, d, adv_lim;
        longint sum, inc;
        bit     good, adv;
        exp_t   it;
        m_rebal();
        e   = (i_v < 0) ? ((q_v < 0) ? -511 : 511) : q_v;
        d   = e - m_elast;
        inc = m_incr(e, m_bw);
        sum = m_integ + inc + m_prop(e, m_bw);
        if (sum > TMAX)   m_tune = TMAX;
        else if (sum < 0) m_tune = 0;
        else begin
            m_tune  = sum;
            m_integ = m_integ + inc;
        end
        good = ((e < 0 ? -e : e) <= int'(phase_thr)) && ((d < 0 ? -d : d) <= int'(freq_thr));
        adv  = m_lock ? !good : good;
        adv_lim = m_lock ? UNLOCK_M : LOCK_N;
        if (adv) begin
            m_cnt++;
            if (m_cnt == adv_lim) begin
                m_lock = !m_lock;
                m_cnt  = 0;
            end
        end else begin
            m_cnt = 0;
        end
        m_elast = e;
        m_hold  = 0;
        it.tune = m_tune;
        it.lock = m_lock;
        it.tag  = tag;
        sb_q.push_back(it);
        @(negedge clk);
        sample_vld = 1'b1;
        sample_i   = i_v[9:0];
        sample_q   = q_v[9:0];
        @(negedge clk);
        sample_vld = 1'b0;
        repeat (2) @(negedge clk);
        m_rebal();
    endtask

    // long gap that runs past the timeout
    task automatic idle_out(input int n);
        repeat (n) @(negedge clk);
        m_hold = 1;
        m_lock = 0;
        m_cnt  = 0;
        m_rebal();
    endtask

    // monitor: compare after every strobe
    initial begin
        bit   seen;
        exp_t it;
        forever begin
            @(posedge clk);
            seen = sample_vld;
            @(negedge clk);
            if (seen) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "scoreboard empty", 0, 1);
                end else begin
                    it = sb_q.pop_front();
                    check(tune_word == it.tune[23:0], it.tag, tune_word, it.tune);
                    check(locked == it.lock, {it.tag, " lock"}, locked, it.lock);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        longint hold_tune;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(tune_word == 24'd8388608, "R1 tune", tune_word, 8388608);
        check(locked == 1'b0, "R1 lock", locked, 0);
        check(holdover == 1'b0, "R1 holdover", holdover, 0);

        // R2 / R3 under several error patterns
        strobe(0, 10, "R3 q=10");
        strobe(5, -20, "R3 q=-20");
        strobe(100, 100, "R3 q=100");
        strobe(-1, 5, "R2 i<0 q>=0");
        strobe(-200, -3, "R2 i<0 q<0");
        strobe(-5, 0, "R2 i<0 q=0");
        strobe(0, -300, "R3 q=-300");

        // R5 lock, then R7 narrow-bandwidth tracking
        work_bw = 3'd3;
        for (int k = 0; k < 10; k++) strobe(0, 2, "R5 small error");
        check(locked == 1'b1, "R5 locked", locked, 1);
        hold_tune = tune_word;
        repeat (4) @(negedge clk);
        check(tune_word == hold_tune[23:0], "R7 no step at switch", tune_word, hold_tune);
        strobe(0, 3, "R7 narrow q=3");
        strobe(0, -1, "R7 narrow q=-1");
        strobe(0, 4, "R7 narrow q=4");
        work_bw = 3'd6;
        repeat (2) @(negedge clk);
        strobe(0, 2, "R7 index change while locked");

        // R6 unlock after a run of large errors
        strobe(0, 100, "R6 bad 1");
        strobe(0, 100, "R6 bad 2");
        strobe(0, 100, "R6 bad 3");
        check(locked == 1'b1, "R6 still locked", locked, 1);
        strobe(0, 100, "R6 bad 4");
        check(locked == 1'b0, "R6 unlocked", locked, 0);

        // relock, then lose the reference: R8 and R9
        for (int k = 0; k < 10; k++) strobe(0, 2, "R5 relock");
        hold_tune = tune_word;
        idle_out(80);
        check(holdover == 1'b1, "R8 holdover", holdover, 1);
        check(locked == 1'b0, "R8 lock cleared", locked, 0);
        check(tune_word == hold_tune[23:0], "R8 tune frozen", tune_word, hold_tune);
        repeat (20) @(negedge clk);
        check(tune_word == hold_tune[23:0], "R10 tune frozen later", tune_word, hold_tune);
        strobe(0, 1, "R9 resume");
        check(holdover == 1'b0, "R9 holdover cleared", holdover, 0);

        // R4 upper rail and anti-windup
        for (int k = 0; k < 400 && m_tune != TMAX; k++) strobe(0, 511, "R4 drive up");
        strobe(0, 511, "R4 at top");
        strobe(0, 511, "R4 at top");
        check(tune_word == 24'hFFFFFF, "R4 top clamp", tune_word, TMAX);
        strobe(0, 0, "R4 release top");
        check(tune_word < 24'hFFFFFF, "R4 leaves top", tune_word, TMAX - 1);

        // R4 lower rail and anti-windup
        for (int k = 0; k < 800 && m_tune != 0; k++) strobe(0, -511, "R4 drive down");
        strobe(0, -511, "R4 at bottom");
        check(tune_word == 24'd0, "R4 bottom clamp", tune_word, 0);
        strobe(0, 0, "R4 release bottom");
        check(tune_word > 24'd0, "R4 leaves bottom", tune_word, 1);

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule